// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 8-bit processor core and runs the fixed-length hardware steps that enter and leave an interrupt handler. It holds one pending flag per interrupt source and a global interrupt enable flag. At an instruction boundary, or while the core sleeps, it accepts the highest-priority pending source. Entry then saves the return address on a downward-growing byte stack and loads the program counter with the source's vector. On a return-from-interrupt event it restores the saved address and sets the enable flag again.

The core reports completed instructions with `insn_done` and reports decoded enable-set and return instructions on the same strobe. It stalls fetch while `busy` is high. Stack traffic goes to a synchronous byte memory: a write lands at the clock edge, and read data appears on `mem_rdata` one cycle after the request. Software can load either byte of the 16-bit stack pointer while the sequencer is idle. Source `i` (bit `i` of `irq_set`) uses vector slot `i+1`, because slot 0 is kept for reset.

Top module: `irq_seq`

## Requirements
- R1: After reset the stack pointer equals `RAM_TOP` (default 0x00DF). `gie`, `busy`, `pc_load` and every pending flag are 0.
- R2: A pulse on bit `i` of `irq_set` sets pending flag `i`. When several flags are pending, the lowest bit index wins. The vector loaded is `VEC_BASE + i + 1`.
- R3: A source is accepted at a clock edge where `insn_done` is 1, `gie` is 1, a flag is pending and no hold-off is active. `busy` is then high for exactly 4 cycles. `pc_load` is high, with the vector on `pc_value`, only in the fourth of those cycles.
- R4: Entry pushes the return address (`pc_in` at acceptance). In the first busy cycle the low byte is written at the stack pointer. In the second cycle the high byte is written at stack pointer minus 1. The pointer ends 2 lower.
- R5: Acceptance clears `gie` and clears the winning pending flag. Other pending flags keep their value.
- R6: If `sleeping` is 1, acceptance needs no `insn_done`. Entry then takes 4 extra cycles: `busy` is high for 8 cycles, the first push is in the fifth cycle and `pc_load` is in the eighth.
- R7: `sei` together with `insn_done` sets `gie`. The next `insn_done` boundary never accepts an interrupt. The boundary after that one may accept.
- R8: While `insn_done` stays 0 and `sleeping` is 0, no interrupt is accepted, even with `gie` set and flags pending. This covers a multi-cycle instruction that is still running.
- R9: `reti` together with `insn_done` starts a return of exactly 4 busy cycles. The high byte is read first, then the low byte. `pc_value` carries the popped address while `pc_load` is high in the fourth cycle. The stack pointer ends 2 higher, and `gie` reads 1 after the fourth cycle.
- R10: While idle, `sp_wr_hi` and `sp_wr_lo` load the high or low byte of the stack pointer from `sp_wdata`. While `busy` is high these writes are ignored.
- R11: While `gie` is 0, no interrupt is accepted at any boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set | input | NSRC | Per-source request pulses that set pending flags |
| insn_done | input | 1 | Instruction-boundary strobe |
| sleeping | input | 1 | Core is in sleep mode |
| sei | input | 1 | Completing instruction sets global enable |
| reti | input | 1 | Completing instruction is return-from-interrupt |
| pc_in | input | 16 | Return address to save on entry |
| sp_wr_hi | input | 1 | Software write of stack pointer high byte |
| sp_wr_lo | input | 1 | Software write of stack pointer low byte |
| sp_wdata | input | 8 | Software write data |
| mem_rdata | input | 8 | Stack read data, one cycle after request |
| mem_we | output | 1 | Stack byte write request |
| mem_re | output | 1 | Stack byte read request |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write data |
| sp | output | 16 | Current stack pointer |
| gie | output | 1 | Global interrupt enable flag |
| pend | output | NSRC | Pending flags |
| busy | output | 1 | Entry or return in progress; core stalls |
| pc_load | output | 1 | Load program counter from pc_value |
| pc_value | output | 16 | Vector address or popped return address |

## Verification
Entry is exercised from three starting points, each of which separates a different timing path. The first is an ordinary instruction boundary, which gives the 4-cycle entry. The second is a sleeping core with no boundary strobe, which must give 8 cycles, with the push shifted by exactly four. The third is a boundary that follows SEI, which must be refused once and accepted at the next boundary. Two sources are left pending at the same time to show that the lowest index wins while the loser's flag survives. A boundary-free stretch with enable set shows that a long instruction is never cut short. Two round trips, with addresses 0x1234 and 0xABCD, show that the push byte order and the pop byte order reverse each other. A stack pointer write issued mid-entry shows that software writes are ignored while the sequencer runs.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_ENT_WAIT,
    ST_RET1,
    ST_RET2,
    ST_RET3,
    ST_RET4
  } seq_state_e;
endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NSRC = 5,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] grant,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  // Scan from the top down so the lowest set bit is the last to write.
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDXW'(i + 1);
      end
    end
  end

  assign any = |pend;

  // R2
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend) == '0));
endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
  parameter logic [15:0] RAM_TOP = 16'h00DF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec,
  input  logic        inc,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wdata,
  output logic [15:0] sp
);
  logic [15:0] sp_q, sp_n;
  logic        sp_en;

  always_comb begin
    sp_en = dec | inc | wr_hi | wr_lo;
    sp_n  = sp_q;
    if (dec)        sp_n = sp_q - 16'd1;
    else if (inc)   sp_n = sp_q + 16'd1;
    else if (wr_hi) sp_n = {wdata, sp_q[7:0]};
    else if (wr_lo) sp_n = {sp_q[15:8], wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RAM_TOP;
    else if (sp_en) sp_q <= sp_n;
  end

  assign sp = sp_q;
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_seq_pkg::*;
#(
  parameter int ENT_CYC  = 4,
  parameter int WAKE_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        ret_start,
  input  logic        wake,
  input  logic [15:0] pc_in,
  input  logic [15:0] vec_in,
  input  logic [15:0] sp,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        sp_dec,
  output logic        sp_inc,
  output logic        pc_load,
  output logic [15:0] pc_value,
  output logic        busy,
  output logic        ret_last
);
  localparam int CMAX = (ENT_CYC > WAKE_CYC) ? ENT_CYC : WAKE_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_e  st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [15:0] ret_pc_q, vec_q;
  logic [7:0]  hi_q;
  logic        cap_en, hi_en;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept && wake) begin
          st_n  = ST_WAKE;
          cnt_n = CW'(WAKE_CYC - 1);
        end else if (accept) begin
          st_n = ST_PUSH_LO;
        end else if (ret_start) begin
          st_n = ST_RET1;
        end
      end
      ST_WAKE: begin
        if (cnt_q == '0) st_n = ST_PUSH_LO;
        else             cnt_n = cnt_q - CW'(1);
      end
      ST_PUSH_LO: st_n = ST_PUSH_HI;
      ST_PUSH_HI: begin
        st_n  = ST_ENT_WAIT;
        cnt_n = CW'(ENT_CYC - 3);
      end
      ST_ENT_WAIT: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else             cnt_n = cnt_q - CW'(1);
      end
      ST_RET1: st_n = ST_RET2;
      ST_RET2: st_n = ST_RET3;
      ST_RET3: st_n = ST_RET4;
      ST_RET4: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign cap_en = accept && (st_q == ST_IDLE);
  assign hi_en  = (st_q == ST_RET3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
      vec_q    <= '0;
    end else if (cap_en) begin
      ret_pc_q <= pc_in;
      vec_q    <= vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= mem_rdata;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    sp_dec    = 1'b0;
    sp_inc    = 1'b0;
    pc_load   = 1'b0;
    pc_value  = '0;
    ret_last  = 1'b0;
    unique case (st_q)
      ST_PUSH_LO: begin
        mem_we    = 1'b1;
        mem_wdata = ret_pc_q[7:0];
        sp_dec    = 1'b1;
      end
      ST_PUSH_HI: begin
        mem_we    = 1'b1;
        mem_wdata = ret_pc_q[15:8];
        sp_dec    = 1'b1;
      end
      ST_ENT_WAIT: begin
        if (cnt_q == '0) begin
          pc_load  = 1'b1;
          pc_value = vec_q;
        end
      end
      ST_RET1: sp_inc = 1'b1;
      ST_RET2: begin
        mem_re = 1'b1;
        sp_inc = 1'b1;
      end
      ST_RET3: mem_re = 1'b1;
      ST_RET4: begin
        pc_load  = 1'b1;
        pc_value = {hi_q, mem_rdata};
        ret_last = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int          NSRC     = 5,
  parameter logic [15:0] RAM_TOP  = 16'h00DF,
  parameter logic [15:0] VEC_BASE = 16'h0000,
  parameter int          ENT_CYC  = 4,
  parameter int          WAKE_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_set,
  input  logic            insn_done,
  input  logic            sleeping,
  input  logic            sei,
  input  logic            reti,
  input  logic [15:0]     pc_in,
  input  logic            sp_wr_hi,
  input  logic            sp_wr_lo,
  input  logic [7:0]      sp_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [15:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [15:0]     sp,
  output logic            gie,
  output logic [NSRC-1:0] pend,
  output logic            busy,
  output logic            pc_load,
  output logic [15:0]     pc_value
);
  localparam int IDXW = $clog2(NSRC + 1);

  logic [NSRC-1:0] pend_q, pend_n, grant;
  logic            gie_q, gie_n, hold_q, hold_n;
  logic            any, accept, ret_go, ret_last, sp_dec, sp_inc;
  logic [IDXW-1:0] idx;
  logic [15:0]     vec;

  irq_prio #(.NSRC(NSRC), .IDXW(IDXW)) prio_i (
    .clk(clk), .rst_n(rst_n), .pend(pend_q),
    .grant(grant), .any(any), .idx(idx)
  );

  assign vec    = VEC_BASE + 16'(idx);
  assign ret_go = !busy && reti && insn_done;
  assign accept = !busy && gie_q && any && !hold_q && !sei && !ret_go &&
                  (insn_done || sleeping);

  always_comb begin
    pend_n = (pend_q & ~(accept ? grant : '0)) | irq_set;
    gie_n  = gie_q;
    if (accept)                  gie_n = 1'b0;
    else if (ret_last)           gie_n = 1'b1;
    else if (sei && insn_done)   gie_n = 1'b1;
    hold_n = hold_q;
    if (sei && insn_done)        hold_n = 1'b1;
    else if (insn_done)          hold_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      gie_q  <= gie_n;
      hold_q <= hold_n;
    end
  end

  irq_sp #(.RAM_TOP(RAM_TOP)) sp_i (
    .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc),
    .wr_hi(sp_wr_hi && !busy), .wr_lo(sp_wr_lo && !busy),
    .wdata(sp_wdata), .sp(sp)
  );

  irq_fsm #(.ENT_CYC(ENT_CYC), .WAKE_CYC(WAKE_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ret_start(ret_go),
    .wake(sleeping), .pc_in(pc_in), .vec_in(vec), .sp(sp),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .pc_load(pc_load), .pc_value(pc_value),
    .busy(busy), .ret_last(ret_last)
  );

  assign gie  = gie_q;
  assign pend = pend_q;

  // R5
  accept_clr_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie);

  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 16'd1));

  // R9
  ret_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_last |=> gie);

  // R7
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && insn_done) |-> !accept);

  // R3
  entry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sleeping) |=> mem_we);

  // R6
  wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sleeping) |=> (busy && !mem_we));
endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int NSRC = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq_set;
  logic            insn_done, sleeping, sei, reti, sp_wr_hi, sp_wr_lo;
  logic [15:0]     pc_in;
  logic [7:0]      sp_wdata;
  logic [7:0]      mem_rdata;
  logic            mem_we, mem_re, gie, busy, pc_load;
  logic [15:0]     mem_addr, sp, pc_value;
  logic [7:0]      mem_wdata;
  logic [NSRC-1:0] pend;
  logic [7:0]      mem [256];
  int              n_chk = 0;
  int              n_fail = 0;
  int              cyc = 0;

  always #10 clk = ~clk;

  irq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .insn_done(insn_done),
    .sleeping(sleeping), .sei(sei), .reti(reti), .pc_in(pc_in),
    .sp_wr_hi(sp_wr_hi), .sp_wr_lo(sp_wr_lo), .sp_wdata(sp_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp(sp), .gie(gie),
    .pend(pend), .busy(busy), .pc_load(pc_load), .pc_value(pc_value)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    irq_set = '0; insn_done = 0; sleeping = 0; sei = 0; reti = 0;
    sp_wr_hi = 0; sp_wr_lo = 0; sp_wdata = '0;
  endtask

  task automatic t_reset();
    clear_in(); pc_in = '0; mem_rdata = '0; rst_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1", "sp", sp, 16'h00DF);
    chk("R1", "gie", gie, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "pend", pend, 0);
    chk("R1", "pc_load", pc_load, 0);
  endtask

  task automatic t_no_gie();
    irq_set = 5'b00100; step(); irq_set = '0;
    insn_done = 1; step(); insn_done = 0;
    chk("R11", "busy with gie=0", busy, 0);
    chk("R2", "pend after set", pend, 5'b00100);
  endtask

  // Enable, wait through long instruction and hold-off, then enter.
  task automatic t_entry();
    int first_busy;
    irq_set = 5'b10000; step(); irq_set = '0;
    sei = 1; insn_done = 1; step(); sei = 0; insn_done = 0;
    chk("R7", "gie after sei", gie, 1);
    repeat (3) begin
      step();
      chk("R8", "busy without boundary", busy, 0);
    end
    insn_done = 1; step(); insn_done = 0;
    chk("R7", "busy at hold-off boundary", busy, 0);
    pc_in = 16'h1234;
    insn_done = 1; step(); insn_done = 0;
    first_busy = busy;
    chk("R3", "busy cycle1", first_busy, 1);
    chk("R5", "gie cleared", gie, 0);
    chk("R5", "pend winner cleared", pend, 5'b10000);
    chk("R4", "push lo we", mem_we, 1);
    chk("R4", "push lo addr", mem_addr, 16'h00DF);
    chk("R4", "push lo data", mem_wdata, 8'h34);
    step();
    chk("R4", "push hi addr", mem_addr, 16'h00DE);
    chk("R4", "push hi data", mem_wdata, 8'h12);
    step();
    chk("R3", "busy cycle3", busy, 1);
    chk("R3", "no early pc_load", pc_load, 0);
    step();
    chk("R3", "pc_load cycle4", pc_load, 1);
    chk("R2", "vector low source wins", pc_value, 16'h0003);
    step();
    chk("R3", "busy after 4", busy, 0);
    chk("R4", "sp after push", sp, 16'h00DD);
    chk("R4", "mem lo", mem[8'hDF], 8'h34);
    chk("R4", "mem hi", mem[8'hDE], 8'h12);
  endtask

  task automatic t_return(input logic [15:0] exp_pc, input logic [15:0] sp0);
    reti = 1; insn_done = 1; step(); reti = 0; insn_done = 0;
    chk("R9", "busy ret1", busy, 1);
    step();
    chk("R9", "pop hi addr", mem_addr, sp0 + 16'd1);
    chk("R9", "pop hi re", mem_re, 1);
    step();
    chk("R9", "pop lo addr", mem_addr, sp0 + 16'd2);
    step();
    chk("R9", "pc_load ret4", pc_load, 1);
    chk("R9", "popped pc", pc_value, exp_pc);
    chk("R9", "gie still 0", gie, 0);
    step();
    chk("R9", "busy after return", busy, 0);
    chk("R9", "gie restored", gie, 1);
    chk("R9", "sp restored", sp, sp0 + 16'd2);
  endtask

  task automatic t_sleep();
    pc_in = 16'hABCD;
    sleeping = 1; step(); sleeping = 0;
    chk("R6", "accept while asleep", busy, 1);
    chk("R6", "no push cycle1", mem_we, 0);
    step(); step(); step();
    chk("R6", "no push cycle4", mem_we, 0);
    step();
    chk("R6", "push lo cycle5", mem_we, 1);
    chk("R6", "push lo data", mem_wdata, 8'hCD);
    step(); step();
    chk("R6", "no pc_load cycle7", pc_load, 0);
    step();
    chk("R6", "pc_load cycle8", pc_load, 1);
    chk("R6", "vector source4", pc_value, 16'h0005);
    step();
    chk("R6", "busy after 8", busy, 0);
    chk("R5", "pend empty", pend, 0);
  endtask

  task automatic t_sp_write();
    sp_wr_hi = 1; sp_wdata = 8'h01; step();
    sp_wr_hi = 0; sp_wr_lo = 1; sp_wdata = 8'h20; step();
    sp_wr_lo = 0;
    chk("R10", "sp software load", sp, 16'h0120);
    irq_set = 5'b01001; step(); irq_set = '0;
    pc_in = 16'h0777;
    insn_done = 1; step(); insn_done = 0;
    chk("R5", "loser pend kept", pend, 5'b01000);
    step(); step();
    sp_wr_lo = 1; sp_wdata = 8'h55; step(); sp_wr_lo = 0;
    chk("R2", "vector source0", pc_value, 16'h0001);
    step();
    chk("R10", "write ignored while busy", sp, 16'h011E);
  endtask

  initial begin
    t_reset();
    t_no_gie();
    t_entry();
    t_return(16'h1234, 16'h00DD);
    t_sleep();
    t_return(16'hABCD, 16'h00DD);
    t_sp_write();
    finish_run();
  end
endmodule